// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Condition Flags and BCD Correction

This block adds and subtracts two 8-bit operands, with or without an incoming carry, and produces the 8-bit result with five condition flags: carry/borrow, overflow, zero, negative and half carry. It also has a decimal-correction operation. After two packed-BCD bytes are added in binary, this operation uses the half-carry and carry flags saved from that addition to turn the sum into a valid two-digit BCD value.

The flag state lives outside the block. The caller presents the current flags with each operation and keeps the updated flags that come back. Each operation is accepted on a cycle where `op_valid` is high. The result and flags are registered and appear one clock later, marked by `res_valid`. When no operation is accepted, the outputs hold their last values.

Top module: `bcd_alu8`

## Requirements
- R1: Op code 0 (sum) gives `result` = (a + b) mod 256. Op code 1 (sum with carry) also adds flag C. In both, C out is the ninth bit of the full sum (F3 + 0E gives 01 with C = 1).
- R2: Op code 2 (difference) gives `result` = (a - b) mod 256. Op code 3 (difference with borrow) also subtracts flag C. In both, C out is 1 exactly when a borrow occurs (56 - 63 gives F3 with C = 1).
- R3: The flag vector has C at bit 0, V at bit 1, Z at bit 2, N at bit 3 and H at bit 4. For op codes 0 to 4, N out equals bit 7 of `result`, and Z out is 1 exactly when `result` is 00.
- R4: For op codes 0 and 1, V out is 1 when both operands have the same sign and the result has the other sign (73 + 24 sets V). For op codes 2 and 3, V out is 1 when the operands differ in sign and the result's sign differs from a's sign.
- R5: For op codes 0 and 1, H out is the carry out of bit 3. Op codes 2 and 3 pass H in to H out unchanged.
- R6: Op code 4 (decimal correct) works on operand a only. It adds 06 when H in is 1 or the low digit of a is above 9.
- R7: Op code 4 also adds 60 when C in is 1, when the high digit is above 9, or when the high digit is 9 and the low digit is above 9. C out is C in OR the carry of the correction. V and H pass through unchanged. Examples: 98 stays 98, and 9E becomes 04 with C = 1.
- R8: Op codes 5, 6 and 7 return a unchanged as `result`, and return the flags unchanged.
- R9: `result` and `flags_out` are registered. `res_valid` is high exactly one cycle after a cycle with `op_valid` high. With `op_valid` low, `result` and `flags_out` hold their values. Reset clears `result`, `flags_out` and `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept an operation this cycle |
| op_sel | input | 3 | Operation code (0 sum, 1 sum+C, 2 diff, 3 diff-C, 4 decimal correct, 5-7 pass) |
| opnd_a | input | 8 | First operand / accumulator |
| opnd_b | input | 8 | Second operand |
| flags_in | input | 5 | Current flags {H,N,Z,V,C} |
| res_valid | output | 1 | Registered result is new this cycle |
| result | output | 8 | Registered result |
| flags_out | output | 5 | Registered updated flags {H,N,Z,V,C} |

## Verification
Some rules are checked by assertions on every cycle:
- the one-cycle valid timing and the holding of the outputs while idle;
- that N and Z match the registered result;
- that decimal correction never clears a saved carry;
- that subtraction keeps H;
- that the pass codes return a and the flags unchanged.

The arithmetic itself can only be shown by the bench's scenarios, which compare against an integer model:
- carry and borrow values;
- signed overflow;
- the half carry out of bit 3;
- which digit corrections fire for each combination of digits and saved flags, including chained sum-then-correct sequences.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int FLAG_W = 5;
  localparam int OP_W   = 3;

  localparam int FC = 0;
  localparam int FV = 1;
  localparam int FZ = 2;
  localparam int FN = 3;
  localparam int FH = 4;

  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_ADC = 3'd1;
  localparam logic [OP_W-1:0] OP_SUB = 3'd2;
  localparam logic [OP_W-1:0] OP_SBC = 3'd3;
  localparam logic [OP_W-1:0] OP_DAA = 3'd4;

  // one decimal digit is out of range when above nine
  function automatic logic digit_big(input logic [NIB_W-1:0] d);
    return d > 4'd9;
  endfunction

  // carry out of the low nibble of a + b + cin
  function automatic logic nib_carry(input logic [NIB_W-1:0] a,
                                     input logic [NIB_W-1:0] b,
                                     input logic cin);
    logic [NIB_W:0] s;
    s = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
    return s[NIB_W];
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          do_sub,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          v_out,
  output logic          h_out
);
  logic [DW:0] ext;

  always_comb begin
    if (do_sub)
      ext = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    else
      ext = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  end

  assign res   = ext[DW-1:0];
  assign c_out = ext[DW];
  assign h_out = nib_carry(a[NIB_W-1:0], b[NIB_W-1:0], cin);
  assign v_out = do_sub ? ((a[DW-1] != b[DW-1]) && (res[DW-1] != a[DW-1]))
                        : ((a[DW-1] == b[DW-1]) && (res[DW-1] != a[DW-1]));
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
  import alu8_pkg::*;
(
  input  logic [DATA_W-1:0] acc,
  input  logic              h_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              fix_lo,
  output logic              fix_hi
);
  logic [NIB_W-1:0]  lo_d, hi_d;
  logic [DATA_W-1:0] corr;
  logic [DATA_W:0]   sum;

  assign lo_d   = acc[NIB_W-1:0];
  assign hi_d   = acc[DATA_W-1:NIB_W];
  assign fix_lo = h_in || digit_big(lo_d);
  assign fix_hi = c_in || digit_big(hi_d) || ((hi_d == 4'd9) && digit_big(lo_d));

  assign corr  = {(fix_hi ? 4'h6 : 4'h0), (fix_lo ? 4'h6 : 4'h0)};
  assign sum   = {1'b0, acc} + {1'b0, corr};
  assign res   = sum[DATA_W-1:0];
  assign c_out = c_in || sum[DATA_W];
endmodule

// File: rtl/bcd_alu8.sv
module bcd_alu8
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_out
);
  logic [DATA_W-1:0] as_res, da_res, nx_res;
  logic              as_c, as_v, as_h, da_c, fix_lo, fix_hi;
  logic              is_arith, is_sub, is_daa;
  logic [FLAG_W-1:0] nx_flg;

  // registered copies of the request, kept for the assertions
  logic [OP_W-1:0]   op_q;
  logic [FLAG_W-1:0] flg_q;
  logic [DATA_W-1:0] a_q;

  assign is_sub   = (op_sel == OP_SUB) || (op_sel == OP_SBC);
  assign is_daa   = (op_sel == OP_DAA);
  assign is_arith = (op_sel <= OP_SBC);

  alu8_addsub #(.DW(DATA_W)) u_addsub (
    .a(opnd_a), .b(opnd_b),
    .cin((op_sel == OP_ADC || op_sel == OP_SBC) && flags_in[FC]),
    .do_sub(is_sub), .res(as_res), .c_out(as_c), .v_out(as_v), .h_out(as_h)
  );

  alu8_decadj u_decadj (
    .acc(opnd_a), .h_in(flags_in[FH]), .c_in(flags_in[FC]),
    .res(da_res), .c_out(da_c), .fix_lo(fix_lo), .fix_hi(fix_hi)
  );

  always_comb begin
    nx_res = opnd_a;
    nx_flg = flags_in;
    if (is_arith) begin
      nx_res     = as_res;
      nx_flg[FC] = as_c;
      nx_flg[FV] = as_v;
      nx_flg[FH] = is_sub ? flags_in[FH] : as_h;
    end else if (is_daa) begin
      nx_res     = da_res;
      nx_flg[FC] = da_c;
    end
    if (is_arith || is_daa) begin
      nx_flg[FN] = nx_res[DATA_W-1];
      nx_flg[FZ] = (nx_res == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      op_q      <= '0;
      flg_q     <= '0;
      a_q       <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        result    <= nx_res;
        flags_out <= nx_flg;
        op_q      <= op_sel;
        flg_q     <= flags_in;
        a_q       <= opnd_a;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(result) && $stable(flags_out)));
  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_q <= OP_DAA) |-> (flags_out[FZ] == (result == 8'h00)));
  // R3
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_q <= OP_DAA) |-> (flags_out[FN] == result[DATA_W-1]));
  // R7
  daa_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_q == OP_DAA && flg_q[FC]) |-> flags_out[FC]);
  // R5
  sub_half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (op_q == OP_SUB || op_q == OP_SBC)) |-> (flags_out[FH] == flg_q[FH]));
  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_q > OP_DAA) |-> (result == a_q && flags_out == flg_q));
endmodule

// File: tb/tb_bcd_alu8.sv
`timescale 1ns/1ps
module tb_bcd_alu8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_sel = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic [4:0] flags_in = '0;
  logic       res_valid;
  logic [7:0] result;
  logic [4:0] flags_out;

  int errors = 0;
  int checks = 0;
  logic [12:0] exp_q[$];
  string       tag_q[$];
  logic [4:0]  last_f = '0;

  always #10 clk = ~clk;

  bcd_alu8 dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
    .res_valid(res_valid), .result(result), .flags_out(flags_out)
  );

  // integer model; returns {flags[4:0] = H,N,Z,V,C ; result[7:0]}
  function automatic logic [12:0] model(input int op, input int a, input int b, input logic [4:0] f);
    int r, ci, s, sa, sb, lo, hi, add;
    logic c, v, h;
    ci = f[0] ? 1 : 0;
    c = f[0]; v = f[1]; h = f[4]; r = a;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        s = a + b + ci; r = s % 256; c = (s > 255);
        h = ((a % 16) + (b % 16) + ci) > 15;
        v = ((sa + sb + ci) > 127) || ((sa + sb + ci) < -128);
      end
      2, 3: begin
        if (op == 2) ci = 0;
        s = a - b - ci; c = (s < 0); r = (s + 512) % 256;
        v = ((sa - sb - ci) > 127) || ((sa - sb - ci) < -128);
      end
      4: begin
        lo = a % 16; hi = a / 16; add = 0;
        if (f[4] || lo > 9) add += 6;
        if (f[0] || hi > 9 || (hi == 9 && lo > 9)) add += 96;
        s = a + add; r = s % 256; c = f[0] || (s > 255);
      end
      default: return {f, a[7:0]};
    endcase
    return {h, (r > 127), (r == 0), v, c, r[7:0]};
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got flags=%b res=%h, expected flags=%b res=%h",
               tag, act[12:8], act[7:0], exp[12:8], exp[7:0]);
    end
  endtask

  // driver: called at a negedge, leaves at the next negedge
  task automatic drive(input int op, input int a, input int b, input logic [4:0] f, input string tag);
    logic [12:0] e;
    e = model(op, a, b, f);
    op_valid = 1'b1; op_sel = op[2:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; flags_in = f;
    exp_q.push_back(e); tag_q.push_back(tag);
    last_f = e[12:8];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    op_valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected res_valid, got 1 expected 0");
      end else begin
        check(tag_q.pop_front(), {flags_out, result}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [12:0] held;
    repeat (3) @(negedge clk);
    check("R9 reset state", {flags_out, result}, 13'd0);
    checks++;
    if (res_valid !== 1'b0) begin errors++; $display("FAIL R9: res_valid got %b expected 0", res_valid); end
    rst_n = 1'b1;
    @(negedge clk);

    drive(0, 8'hF3, 8'h0E, 5'b00000, "R1 add carry F3+0E");
    drive(1, 8'h10, 8'h20, 5'b00001, "R1 adc with C");
    drive(2, 8'h56, 8'h63, 5'b00000, "R2 sub borrow 56-63");
    drive(3, 8'h66, 8'h63, 5'b00001, "R2 sbc with C");
    drive(0, 8'h73, 8'h24, 5'b00000, "R4 add overflow 73+24");
    drive(2, 8'h80, 8'h01, 5'b00000, "R4 sub overflow 80-01");
    drive(0, 8'h00, 8'h00, 5'b11111, "R3 zero result");
    drive(0, 8'h08, 8'h08, 5'b00000, "R5 half carry 08+08");
    drive(2, 8'h20, 8'h10, 5'b10000, "R5 sub keeps H");
    drive(0, 8'h13, 8'h85, 5'b00000, "R1 BCD add 13+85");
    drive(4, 8'h98, 0, last_f, "R7 decimal correct 98 unchanged");
    drive(0, 8'h19, 8'h85, 5'b00000, "R1 BCD add 19+85");
    drive(4, 8'h9E, 0, last_f, "R7 decimal correct 9E to 04");
    drive(0, 8'h09, 8'h09, 5'b00000, "R5 BCD add 09+09");
    drive(4, 8'h12, 0, last_f, "R6 low fix from saved H");
    drive(4, 8'h3A, 0, 5'b00000, "R6 low digit above 9");
    drive(4, 8'h21, 0, 5'b00001, "R7 high fix from saved C");
    drive(4, 8'hA2, 0, 5'b00010, "R7 high digit above 9, V kept");
    drive(4, 8'h00, 0, 5'b00000, "R3 decimal correct zero");
    drive(5, 8'h5A, 8'h11, 5'b10101, "R8 pass code 5");
    drive(7, 8'hC3, 8'h22, 5'b01010, "R8 pass code 7");
    idle(2);

    // R9: outputs hold while idle
    held = {flags_out, result};
    idle(4);
    check("R9 hold while idle", {flags_out, result}, held);

    for (int i = 0; i < 200; i++) begin
      int op = i % 5;
      drive(op, (i * 37 + 11) % 256, (i * 91 + 5) % 256, 5'((i * 13) % 32),
            (op < 2) ? "R1 sweep" : (op < 4) ? "R2 sweep" : "R6 sweep");
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: pending results got %0d expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule